// File: doc/BRIEF.md
# Network Interface Command/Status Register

This block is the 16-bit command and status word that sits between software and a network interface datapath. One written word carries three independent command groups (transmit, receive and test). Each group carries its own active-low qualifier bit inside the word, so a write can change one group and leave the other two as they are. Most command bits are held levels that drive the datapath directly. End-of-packet, wait-for-packet-start and forced-collision are one-cycle strobes.

Reading the register returns the station address in the upper byte and the interface state in the lower byte. The lower byte includes two sticky error flags, data-late and parity error, which the datapath reports as single-cycle events. A transmitter off-to-on write clears them, so the usual recovery after an aborted transmission is to write the transmitter off and then on. A test write that asks for transmit reset or bypass forces both directions off. The usual reset sequence is therefore a reset-plus-bypass word followed by an all-zero word.

Top module: `netif_ctl_reg`

## Requirements
- R1: After reset every level output and strobe is 0, and the low byte of rd_data is 0x00.
- R2: On a write with bit 15 = 0, tx_on takes bit 14 and odd_last takes bit 12. With bit 15 = 1 both keep their value.
- R3: On a write with bit 11 = 0, rx_on takes bit 10. With bit 11 = 1 it keeps its value.
- R4: On a write with bit 7 = 0, loopback takes bit 6, tx_reset takes bit 5, wake_off takes bit 4 and bypass takes bit 1. With bit 7 = 1 all four keep their value.
- R5: eop_pulse is high for exactly the one cycle after a write with bit 15 = 0 and bit 13 = 1.
- R6: rx_wait_pulse is high for exactly the one cycle after a write with bit 11 = 0, bit 10 = 1 and bit 9 = 0.
- R7: coll_pulse is high for exactly the one cycle after a write with bit 7 = 0 and bit 0 = 1.
- R8: A write with bit 7 = 0 and bit 5 or bit 1 set turns tx_on and rx_on off. This overrides whatever the transmit and receive groups of the same word ask for.
- R9: rd_data[15:8] equals station_addr. rd_data[7:0] holds rx_on at bit 7, tx_on at bit 6, loopback at bit 5, bypass at bit 4, wake_off at bit 3, the data-late flag at bit 2, zero at bit 1 and the parity flag at bit 0.
- R10: A high late_evt or parity_evt sets its flag on the next edge. The flag then stays set until it is cleared as R11 describes.
- R11: A write with bit 15 = 0 and bit 14 = 1 while tx_on is 0 clears both flags. An event in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 16 | Command word with three self-qualified groups |
| station_addr | input | 8 | Station address byte returned on read |
| late_evt | input | 1 | Datapath event: transmit data arrived late |
| parity_evt | input | 1 | Datapath event: parity error seen |
| rd_data | output | 16 | Status word |
| tx_on | output | 1 | Transmitter enable |
| rx_on | output | 1 | Receiver enable |
| odd_last | output | 1 | Final byte of the packet goes in the upper half |
| eop_pulse | output | 1 | One-cycle end-of-packet request |
| rx_wait_pulse | output | 1 | One-cycle request to wait for the next packet start |
| loopback | output | 1 | Loopback mode |
| tx_reset | output | 1 | Transmit reset / single-step |
| wake_off | output | 1 | Task wakeups disabled |
| bypass | output | 1 | Controller bypassed and held in reset |
| coll_pulse | output | 1 | One-cycle forced collision |

## Verification
A stimulus table runs a series of words. Some enable one group at a time, some enable all three, some enable none (0xFFFF), and some set bits inside disabled groups. This shows whether the qualifier bits alone decide which fields change. Words that request transmit or receive turn-on together with a reset or bypass test command show whether the override wins. Each strobe is checked on the cycle after its write and again one cycle later, to tell a pulse from a level. Directed sequences then raise the error events while the transmitter is on. They write the transmitter on again while it is already on, write it off and then on, and raise an event in the same cycle as a turn-on. This tells sticky behaviour apart from edge-triggered clearing and shows which of set and clear has priority.

// File: rtl/netif_ctl_pkg.sv
package netif_ctl_pkg;
  localparam int unsigned STA_W  = 8;
  localparam int unsigned WORD_W = 2 * STA_W;
  localparam int unsigned N_ERR  = 2;

  // write word bit positions (the layout is fixed by software)
  localparam int unsigned B_TX_QUAL = 15;
  localparam int unsigned B_TX_ON   = 14;
  localparam int unsigned B_TX_EOP  = 13;
  localparam int unsigned B_TX_ODD  = 12;
  localparam int unsigned B_RX_QUAL = 11;
  localparam int unsigned B_RX_ON   = 10;
  localparam int unsigned B_RX_SOPN = 9;
  localparam int unsigned B_TS_QUAL = 7;
  localparam int unsigned B_TS_LPBK = 6;
  localparam int unsigned B_TS_TRST = 5;
  localparam int unsigned B_TS_NWAK = 4;
  localparam int unsigned B_TS_BYP  = 1;
  localparam int unsigned B_TS_COLL = 0;

  typedef struct packed {
    logic tx_sel;
    logic tx_on;
    logic tx_eop;
    logic tx_odd;
    logic rx_sel;
    logic rx_on;
    logic rx_wait;
    logic ts_sel;
    logic ts_lpbk;
    logic ts_trst;
    logic ts_nwak;
    logic ts_byp;
    logic ts_coll;
  } cmd_t;

  typedef struct packed {
    logic tx_on;
    logic odd;
    logic rx_on;
    logic lpbk;
    logic trst;
    logic nwak;
    logic byp;
  } lvl_t;

  typedef struct packed {
    logic eop;
    logic rx_wait;
    logic coll;
  } pul_t;
endpackage

// File: rtl/netif_rst_sync.sv
module netif_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/netif_cmd_decode.sv
module netif_cmd_decode
  import netif_ctl_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);
  logic unused_bits;
  assign unused_bits = ^word[3:2];

  always_comb begin
    cmd.tx_sel  = ~word[B_TX_QUAL];
    cmd.tx_on   =  word[B_TX_ON];
    cmd.tx_eop  =  word[B_TX_EOP];
    cmd.tx_odd  =  word[B_TX_ODD];
    cmd.rx_sel  = ~word[B_RX_QUAL];
    cmd.rx_on   =  word[B_RX_ON];
    cmd.rx_wait =  word[B_RX_ON] & ~word[B_RX_SOPN];
    cmd.ts_sel  = ~word[B_TS_QUAL];
    cmd.ts_lpbk =  word[B_TS_LPBK];
    cmd.ts_trst =  word[B_TS_TRST];
    cmd.ts_nwak =  word[B_TS_NWAK];
    cmd.ts_byp  =  word[B_TS_BYP];
    cmd.ts_coll =  word[B_TS_COLL];
  end
endmodule

// File: rtl/netif_ctl_state.sv
module netif_ctl_state
  import netif_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cmd_t cmd,
  output lvl_t lvl,
  output pul_t pul,
  output logic tx_turn_on
);
  lvl_t lvl_q, lvl_d;
  pul_t pul_q, pul_d;
  logic force_off;

  assign force_off  = cmd.ts_sel & (cmd.ts_trst | cmd.ts_byp);
  assign tx_turn_on = wr_en & cmd.tx_sel & cmd.tx_on & ~lvl_q.tx_on;

  always_comb begin
    lvl_d = lvl_q;
    if (cmd.tx_sel) begin
      lvl_d.tx_on = cmd.tx_on;
      lvl_d.odd   = cmd.tx_odd;
    end
    if (cmd.rx_sel) lvl_d.rx_on = cmd.rx_on;
    if (cmd.ts_sel) begin
      lvl_d.lpbk = cmd.ts_lpbk;
      lvl_d.trst = cmd.ts_trst;
      lvl_d.nwak = cmd.ts_nwak;
      lvl_d.byp  = cmd.ts_byp;
    end
    if (force_off) begin
      lvl_d.tx_on = 1'b0;
      lvl_d.rx_on = 1'b0;
    end
  end

  always_comb begin
    pul_d.eop     = wr_en & cmd.tx_sel & cmd.tx_eop;
    pul_d.rx_wait = wr_en & cmd.rx_sel & cmd.rx_wait;
    pul_d.coll    = wr_en & cmd.ts_sel & cmd.ts_coll;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      pul_q <= '0;
    end else begin
      if (wr_en) lvl_q <= lvl_d;
      pul_q <= pul_d;
    end
  end

  assign lvl = lvl_q;
  assign pul = pul_q;
endmodule

// File: rtl/netif_err_sticky.sv
module netif_err_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d;
    assign d = set_evt[i] | (q & ~clr);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flag[i] = q;
  end
endmodule

// File: rtl/netif_ctl_reg.sv
module netif_ctl_reg
  import netif_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [STA_W-1:0]  station_addr,
  input  logic              late_evt,
  input  logic              parity_evt,
  output logic [WORD_W-1:0] rd_data,
  output logic              tx_on,
  output logic              rx_on,
  output logic              odd_last,
  output logic              eop_pulse,
  output logic              rx_wait_pulse,
  output logic              loopback,
  output logic              tx_reset,
  output logic              wake_off,
  output logic              bypass,
  output logic              coll_pulse
);
  logic             rst_n_s;
  cmd_t             cmd;
  lvl_t             lvl;
  pul_t             pul;
  logic             turn_on;
  logic [N_ERR-1:0] err;

  netif_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  netif_cmd_decode u_dec (.word(wr_data), .cmd(cmd));

  netif_ctl_state u_state (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .cmd(cmd),
    .lvl(lvl), .pul(pul), .tx_turn_on(turn_on)
  );

  // err[1] = data late, err[0] = parity
  netif_err_sticky #(.N(N_ERR)) u_err (
    .clk(clk), .rst_n(rst_n_s), .set_evt({late_evt, parity_evt}),
    .clr(turn_on), .flag(err)
  );

  assign tx_on         = lvl.tx_on;
  assign rx_on         = lvl.rx_on;
  assign odd_last      = lvl.odd;
  assign loopback      = lvl.lpbk;
  assign tx_reset      = lvl.trst;
  assign wake_off      = lvl.nwak;
  assign bypass        = lvl.byp;
  assign eop_pulse     = pul.eop;
  assign rx_wait_pulse = pul.rx_wait;
  assign coll_pulse    = pul.coll;

  assign rd_data = {station_addr, lvl.rx_on, lvl.tx_on, lvl.lpbk, lvl.byp,
                    lvl.nwak, err[1], 1'b0, err[0]};
endmodule

// File: rtl/netif_ctl_reg_chk.sv
module netif_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        late_evt,
  input logic [15:0] rd_data,
  input logic        tx_on,
  input logic        rx_on,
  input logic        eop_pulse,
  input logic        rx_wait_pulse,
  input logic        loopback,
  input logic        tx_reset,
  input logic        wake_off,
  input logic        bypass,
  input logic        coll_pulse
);
  logic kill_wr;
  logic on_wr;
  assign kill_wr = wr_en && !wr_data[7] && (wr_data[5] || wr_data[1]);
  assign on_wr   = wr_en && !wr_data[15] && wr_data[14] && !tx_on;

  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_en || wr_data[15]) && !kill_wr) |=> $stable(tx_on));
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_en || wr_data[11]) && !kill_wr) |=> $stable(rx_on));
  a_r4_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_data[7]) |=> $stable({loopback, tx_reset, wake_off, bypass}));
  a_r5_eop_src: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pulse |-> $past(wr_en && !wr_data[15] && wr_data[13]));
  a_r6_wait_src: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wait_pulse |-> $past(wr_en && !wr_data[11] && wr_data[10] && !wr_data[9]));
  a_r7_coll_src: assert property (@(posedge clk) disable iff (!rst_n)
    coll_pulse |-> $past(wr_en && !wr_data[7] && wr_data[0]));
  a_r8_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wr |=> (!tx_on && !rx_on));
  a_r10_late_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] && !on_wr) |=> rd_data[2]);
  a_r11_late_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (on_wr && !late_evt) |=> !rd_data[2]);
endmodule

bind netif_ctl_reg netif_ctl_reg_chk chk_i (.*);

// File: tb/netif_ctl_reg_tb_top.sv
module netif_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  station_addr = 8'hA5;
  logic        late_evt = 1'b0;
  logic        parity_evt = 1'b0;
  logic [15:0] rd_data;
  logic tx_on, rx_on, odd_last, eop_pulse, rx_wait_pulse;
  logic loopback, tx_reset, wake_off, bypass, coll_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  netif_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .station_addr(station_addr), .late_evt(late_evt), .parity_evt(parity_evt),
    .rd_data(rd_data), .tx_on(tx_on), .rx_on(rx_on), .odd_last(odd_last),
    .eop_pulse(eop_pulse), .rx_wait_pulse(rx_wait_pulse), .loopback(loopback),
    .tx_reset(tx_reset), .wake_off(wake_off), .bypass(bypass),
    .coll_pulse(coll_pulse)
  );

  // {wdata, expected low byte, {eop, wait, coll}, {tx_reset, odd_last}, pad}
  localparam logic [31:0] VEC [12] = '{
    {16'h4888, 8'h40, 3'b000, 2'b00, 3'b0},  // R2 tx on alone
    {16'h8688, 8'hC0, 3'b000, 2'b00, 3'b0},  // R3 rx on, no wait
    {16'h8840, 8'hE0, 3'b000, 2'b00, 3'b0},  // R4 loopback
    {16'h6890, 8'hE0, 3'b100, 2'b00, 3'b0},  // R5 eop, test bits ignored
    {16'h8410, 8'hC8, 3'b010, 2'b00, 3'b0},  // R6 wait, wake_off
    {16'h7801, 8'hC0, 3'b101, 2'b01, 3'b0},  // R7 coll + eop + odd
    {16'h0022, 8'h10, 3'b000, 2'b10, 3'b0},  // R8 reset+bypass
    {16'h0000, 8'h00, 3'b000, 2'b00, 3'b0},  // R8 then zero
    {16'hFFFF, 8'h00, 3'b000, 2'b00, 3'b0},  // R2 R3 R4 all groups masked
    {16'h4800, 8'h40, 3'b000, 2'b00, 3'b0},  // R2 tx on again
    {16'h4622, 8'h10, 3'b000, 2'b10, 3'b0},  // R8 override of on requests
    {16'h0000, 8'h00, 3'b000, 2'b00, 3'b0}   // R4 clear
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic le);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; late_evt = le;
    @(posedge clk); #1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; late_evt = 1'b0;
  endtask

  task automatic evt(input logic le, input logic pe);
    @(negedge clk);
    late_evt = le; parity_evt = pe;
    @(negedge clk);
    late_evt = 1'b0; parity_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({8'h00, rd_data[7:0]}, 16'h0000, "R1 low byte");
    chk({6'd0, tx_on, rx_on, odd_last, loopback, tx_reset, wake_off, bypass,
         eop_pulse, rx_wait_pulse, coll_pulse}, 16'h0000, "R1 outputs");
    chk({8'h00, rd_data[15:8]}, 16'h00A5, "R9 station byte");

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = VEC[i][31:16];
      @(posedge clk); #1;
      chk({8'h00, rd_data[7:0]}, {8'h00, VEC[i][15:8]}, "R9 R2 R3 R4 R8 status");
      chk({13'd0, eop_pulse, rx_wait_pulse, coll_pulse}, {13'd0, VEC[i][7:5]},
          "R5 R6 R7 strobes");
      chk({14'd0, tx_reset, odd_last}, {14'd0, VEC[i][4:3]}, "R4 R2 levels");
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      @(posedge clk); #1;
      chk({13'd0, eop_pulse, rx_wait_pulse, coll_pulse}, 16'h0000, "R5 R6 R7 one cycle");
    end

    // R9 station byte follows its input
    @(negedge clk); station_addr = 8'h3C;
    @(negedge clk); chk(rd_data, 16'h3C00, "R9 read word");

    // R10 / R11 sticky flags
    wr(16'h4880, 1'b0); chk({8'h00, rd_data[7:0]}, 16'h0040, "R11 tx on");
    evt(1'b1, 1'b0);    chk({8'h00, rd_data[7:0]}, 16'h0044, "R10 late set");
    repeat (3) @(negedge clk);
    chk({8'h00, rd_data[7:0]}, 16'h0044, "R10 late held");
    evt(1'b0, 1'b1);    chk({8'h00, rd_data[7:0]}, 16'h0045, "R10 parity set");
    wr(16'h4880, 1'b0); chk({8'h00, rd_data[7:0]}, 16'h0045, "R11 no clear when on");
    wr(16'h0880, 1'b0); chk({8'h00, rd_data[7:0]}, 16'h0005, "R10 kept when off");
    wr(16'h4880, 1'b0); chk({8'h00, rd_data[7:0]}, 16'h0040, "R11 clear on turn on");
    wr(16'h0880, 1'b0); chk({8'h00, rd_data[7:0]}, 16'h0000, "R2 tx off");
    wr(16'h4880, 1'b1); chk({8'h00, rd_data[7:0]}, 16'h0044, "R11 set wins");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule